// File: doc/BRIEF.md
# Synthesizer Divider and Phase-Frequency Detector Core

This block is the digital heart of a frequency synthesizer loop. It runs on one fast sampling clock. Two strobe inputs each mark one cycle of the signals it compares. The feedback strobe stands for one cycle of the RF signal, which has already been prescaled by eight. The reference strobe stands for one cycle of the crystal reference. A programmable feedback divider of up to 15 bits divides the feedback strobe. A reference divider divides the reference strobe by one of three selectable ratios, which default to 512, 640 and 1024.

The two divided edges drive a phase-frequency detector. It produces pump-up and pump-down pulses for the external charge pump. A lock detector watches the width of those pulses over successive comparison periods and drives an active-low lock flag. When automatic current switching is enabled and the loop is locked, the charge-pump current select is forced low and a status flag reports the switch. Settings arrive on parallel inputs and take effect on a load strobe. A load also restarts both dividers and the detector. The tuning output stays disabled from power-on reset until the first load.

Top module: `synth_pfd_core`

## Requirements
- R1: The feedback divider emits one divided edge for every max(N,1) feedback strobes, where N is the unsigned value of `cfg_ratio` captured at the last load. N = 0 acts as N = 1.
- R2: The reference divider ratio is chosen by `cfg_refsel` (bit 1 = RSB, bit 0 = RSA). The code 00 selects the middle ratio (default 640). The code 01 selects the high ratio (default 1024). The codes 10 and 11 select the low ratio (default 512). Both dividers restart on a load, so the loop locks exactly when N equals the selected ratio.
- R3: A divided reference edge that comes first raises `pump_up` in the next cycle. A divided feedback edge that comes first raises `pump_dn` in the next cycle. The raised pulse falls in the cycle after the other edge arrives.
- R4: `pump_up` and `pump_dn` are never high together. Divided edges that coincide produce no pulse at all.
- R5: `lock_n` goes low after 4 consecutive comparison periods in which no pump pulse lasts for 2 or more reference strobes. A period ends at each divided reference edge. The first period starts at the load. With both strobes present in every cycle and N equal to the ratio R, `lock_n` falls in the cycle after clock edge 4R+1, counting the load edge as edge 0.
- R6: `lock_n` returns high at the end of the first comparison period that holds a pump pulse of 2 or more reference strobes.
- R7: `cp_hi` follows the `cfg_cp` value captured at the last load. The exception is when the captured `cfg_auto` is 1 and the loop is locked: then `cp_hi` is 0 and `acp` is 0. In every other case `acp` is 1.
- R8: After reset, `cp_hi` = 1, `acp` = 1, `lock_n` = 1, `tune_en` = 0, `pump_up` = 0 and `pump_dn` = 0.
- R9: A load sets `tune_en` to 1 and clears lock, so `lock_n` is 1 in the cycle after the load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rf_en | input | 1 | One cycle per prescaled RF cycle |
| ref_en | input | 1 | One cycle per reference cycle |
| cfg_load | input | 1 | Captures the settings and restarts the loop |
| cfg_ratio | input | N_W | Feedback division ratio N |
| cfg_refsel | input | 2 | Reference ratio select, RSB:RSA |
| cfg_cp | input | 1 | Charge-pump current: 1 = high, 0 = low |
| cfg_auto | input | 1 | Enables automatic current reduction on lock |
| pump_up | output | 1 | Charge-pump up pulse |
| pump_dn | output | 1 | Charge-pump down pulse |
| cp_hi | output | 1 | Effective charge-pump current select |
| acp | output | 1 | Low while automatic reduction is active |
| lock_n | output | 1 | Low while locked |
| tune_en | output | 1 | Tuning output enable |

## Verification
The bench builds the core with a 6-bit feedback ratio and reference ratios of 8, 10 and 16. Both strobes are present in every cycle. This small configuration lets the bench sweep every feedback ratio from 0 to 63 against every reference select code and predict lock purely from whether N equals the selected ratio. The short periods also bring the exact cycle of each pump pulse and of the lock transition within reach. They also make it quick to lose lock by withholding the feedback strobe.

// File: rtl/spc_pkg.sv
package spc_pkg;

   typedef enum logic [1:0] {
      RS_MID    = 2'b00,
      RS_HI     = 2'b01,
      RS_LO     = 2'b10,
      RS_LO_ALT = 2'b11
   } ref_sel_e;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      return m;
   endfunction

endpackage

// File: rtl/spc_fb_div.sv
module spc_fb_div #(
   parameter int N_W = 15
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           clr,
   input  logic           en,
   input  logic [N_W-1:0] ratio,
   output logic           tick
);
   logic [N_W-1:0] cnt;
   logic [N_W-1:0] lim;

   // ratio 0 and 1 both give an edge on every strobe
   always_comb lim = (ratio <= N_W'(1)) ? '0 : ratio - N_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         tick <= 1'b0;
      end else if (clr) begin
         cnt  <= '0;
         tick <= 1'b0;
      end else begin
         tick <= en && (cnt >= lim);
         if (en) cnt <= (cnt >= lim) ? '0 : cnt + N_W'(1);
      end
   end
endmodule

// File: rtl/spc_ref_div.sv
module spc_ref_div #(
   parameter int DIV_LO  = 512,
   parameter int DIV_MID = 640,
   parameter int DIV_HI  = 1024
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       en,
   input  logic [1:0] sel,
   output logic       tick
);
   import spc_pkg::*;

   localparam int CW = $clog2(max3(DIV_LO, DIV_MID, DIV_HI));

   logic [CW-1:0] cnt;
   logic [CW-1:0] lim;

   always_comb begin
      case (ref_sel_e'(sel))
         RS_MID:  lim = CW'(DIV_MID - 1);
         RS_HI:   lim = CW'(DIV_HI - 1);
         default: lim = CW'(DIV_LO - 1);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         tick <= 1'b0;
      end else if (clr) begin
         cnt  <= '0;
         tick <= 1'b0;
      end else begin
         tick <= en && (cnt >= lim);
         if (en) cnt <= (cnt >= lim) ? '0 : cnt + CW'(1);
      end
   end
endmodule

// File: rtl/spc_pfd.sv
module spc_pfd (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic ref_tick,
   input  logic fb_tick,
   output logic up,
   output logic dn
);
   logic up_nx, dn_nx;

   always_comb begin
      up_nx = up | ref_tick;
      dn_nx = dn | fb_tick;
      // mutual clear: both set means both edges seen, end the pulse
      if (up_nx && dn_nx) begin
         up_nx = 1'b0;
         dn_nx = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         up <= 1'b0;
         dn <= 1'b0;
      end else if (clr) begin
         up <= 1'b0;
         dn <= 1'b0;
      end else begin
         up <= up_nx;
         dn <= dn_nx;
      end
   end
endmodule

// File: rtl/spc_lock.sv
module spc_lock #(
   parameter int LOCK_CNT    = 4,
   parameter int WIDTH_LIMIT = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic ref_en,
   input  logic ref_tick,
   input  logic up,
   input  logic dn,
   output logic locked
);
   localparam int GW = $clog2(LOCK_CNT + 1);

   logic          active;
   logic          long_now;
   logic          bad;
   logic [GW-1:0] good;

   assign active = up | dn;

   generate
      if (WIDTH_LIMIT == 1) begin : g_any
         assign long_now = active & ref_en;
      end else begin : g_count
         localparam int WW = $clog2(WIDTH_LIMIT + 1);
         logic [WW-1:0] wcnt;
         assign long_now = active & ref_en & (wcnt == WW'(WIDTH_LIMIT - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                      wcnt <= '0;
            else if (clr || !active)                         wcnt <= '0;
            else if (ref_en && wcnt != WW'(WIDTH_LIMIT - 1)) wcnt <= wcnt + WW'(1);
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bad  <= 1'b0;
         good <= '0;
      end else if (clr) begin
         bad  <= 1'b0;
         good <= '0;
      end else if (ref_tick) begin
         bad <= 1'b0;
         if (bad || long_now)           good <= '0;
         else if (good != GW'(LOCK_CNT)) good <= good + GW'(1);
      end else if (long_now) begin
         bad <= 1'b1;
      end
   end

   assign locked = (good == GW'(LOCK_CNT));
endmodule

// File: rtl/synth_pfd_core.sv
module synth_pfd_core #(
   parameter int N_W         = 15,
   parameter int DIV_LO      = 512,
   parameter int DIV_MID     = 640,
   parameter int DIV_HI      = 1024,
   parameter int LOCK_CNT    = 4,
   parameter int WIDTH_LIMIT = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           rf_en,
   input  logic           ref_en,
   input  logic           cfg_load,
   input  logic [N_W-1:0] cfg_ratio,
   input  logic [1:0]     cfg_refsel,
   input  logic           cfg_cp,
   input  logic           cfg_auto,
   output logic           pump_up,
   output logic           pump_dn,
   output logic           cp_hi,
   output logic           acp,
   output logic           lock_n,
   output logic           tune_en
);
   generate
      if (N_W < 2 || N_W > 15) begin : g_bad_nw
         $error("synth_pfd_core: N_W must lie in 2..15");
      end
      if (DIV_LO < 2 || DIV_MID < 2 || DIV_HI < 2) begin : g_bad_div
         $error("synth_pfd_core: reference ratios must be at least 2");
      end
      if (LOCK_CNT < 1 || WIDTH_LIMIT < 1) begin : g_bad_lock
         $error("synth_pfd_core: lock parameters must be at least 1");
      end
   endgenerate

   logic [N_W-1:0] ratio_q;
   logic [1:0]     refsel_q;
   logic           cp_q, auto_q, tune_q;
   logic           ref_tick, rf_tick, locked;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ratio_q  <= '0;
         refsel_q <= 2'b00;
         cp_q     <= 1'b1;
         auto_q   <= 1'b0;
         tune_q   <= 1'b0;
      end else if (cfg_load) begin
         ratio_q  <= cfg_ratio;
         refsel_q <= cfg_refsel;
         cp_q     <= cfg_cp;
         auto_q   <= cfg_auto;
         tune_q   <= 1'b1;
      end
   end

   spc_fb_div #(.N_W(N_W)) u_fb (
      .clk(clk), .rst_n(rst_n), .clr(cfg_load), .en(rf_en),
      .ratio(ratio_q), .tick(rf_tick)
   );

   spc_ref_div #(.DIV_LO(DIV_LO), .DIV_MID(DIV_MID), .DIV_HI(DIV_HI)) u_ref (
      .clk(clk), .rst_n(rst_n), .clr(cfg_load), .en(ref_en),
      .sel(refsel_q), .tick(ref_tick)
   );

   spc_pfd u_pfd (
      .clk(clk), .rst_n(rst_n), .clr(cfg_load),
      .ref_tick(ref_tick), .fb_tick(rf_tick),
      .up(pump_up), .dn(pump_dn)
   );

   spc_lock #(.LOCK_CNT(LOCK_CNT), .WIDTH_LIMIT(WIDTH_LIMIT)) u_lock (
      .clk(clk), .rst_n(rst_n), .clr(cfg_load), .ref_en(ref_en),
      .ref_tick(ref_tick), .up(pump_up), .dn(pump_dn), .locked(locked)
   );

   assign lock_n  = ~locked;
   assign acp     = ~(auto_q & locked);
   assign cp_hi   = cp_q & acp;
   assign tune_en = tune_q;
endmodule

// File: rtl/spc_chk.sv
module spc_chk (
   input logic clk,
   input logic rst_n,
   input logic cfg_load,
   input logic ref_tick,
   input logic rf_tick,
   input logic pump_up,
   input logic pump_dn,
   input logic cp_hi,
   input logic acp,
   input logic lock_n,
   input logic tune_en
);
   assert_no_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(pump_up && pump_dn));

   assert_up_from_ref_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pump_up) |-> $past(ref_tick));

   assert_dn_from_fb_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pump_dn) |-> $past(rf_tick));

   assert_lock_at_period_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lock_n) |-> $past(ref_tick));

   assert_unlock_at_period_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock_n) |-> ($past(ref_tick) || $past(cfg_load)));

   assert_acp_forces_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !acp |-> (!cp_hi && !lock_n));

   assert_reset_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (cp_hi && acp && lock_n && !tune_en && !pump_up && !pump_dn));

   assert_load_restarts_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_load |=> (lock_n && tune_en));
endmodule

bind synth_pfd_core spc_chk u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load),
   .ref_tick(ref_tick), .rf_tick(rf_tick),
   .pump_up(pump_up), .pump_dn(pump_dn),
   .cp_hi(cp_hi), .acp(acp), .lock_n(lock_n), .tune_en(tune_en)
);

// File: tb/sim_synth_pfd_core.sv
module sim_synth_pfd_core;
   localparam int CLK_PERIOD = 10;
   localparam int NW   = 6;
   localparam int RLO  = 8;
   localparam int RMID = 10;
   localparam int RHI  = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rf_en = 1'b1, ref_en = 1'b1;
   logic cfg_load = 1'b0;
   logic [NW-1:0] cfg_ratio = '0;
   logic [1:0] cfg_refsel = 2'b00;
   logic cfg_cp = 1'b1, cfg_auto = 1'b0;
   logic pump_up, pump_dn, cp_hi, acp, lock_n, tune_en;

   int n_tests = 0;
   int n_fail  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   synth_pfd_core #(.N_W(NW), .DIV_LO(RLO), .DIV_MID(RMID), .DIV_HI(RHI)) u0 (
      .clk(clk), .rst_n(rst_n), .rf_en(rf_en), .ref_en(ref_en),
      .cfg_load(cfg_load), .cfg_ratio(cfg_ratio), .cfg_refsel(cfg_refsel),
      .cfg_cp(cfg_cp), .cfg_auto(cfg_auto),
      .pump_up(pump_up), .pump_dn(pump_dn), .cp_hi(cp_hi), .acp(acp),
      .lock_n(lock_n), .tune_en(tune_en)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int ratio_of(input int sel);
      case (sel)
         0: return RMID;
         1: return RHI;
         default: return RLO;
      endcase
   endfunction

   // leaves time just after load edge E0 (at the following negedge)
   task automatic do_load(input int n, input int sel, input bit cp, input bit aut);
      @(negedge clk);
      cfg_ratio  = NW'(n);
      cfg_refsel = 2'(sel);
      cfg_cp     = cp;
      cfg_auto   = aut;
      cfg_load   = 1'b1;
      @(negedge clk);
      cfg_load   = 1'b0;
   endtask

   task automatic step(input int k);
      repeat (k) @(posedge clk);
      #1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R8 reset state
      chk("R8 cp_hi", int'(cp_hi), 1);
      chk("R8 acp", int'(acp), 1);
      chk("R8 lock_n", int'(lock_n), 1);
      chk("R8 tune_en", int'(tune_en), 0);
      chk("R8 pump_up", int'(pump_up), 0);
      chk("R8 pump_dn", int'(pump_dn), 0);
      @(negedge clk);
      rst_n = 1'b1;
      step(2);
      chk("R8 lock_n after release", int'(lock_n), 1);
      chk("R8 tune_en after release", int'(tune_en), 0);

      // R3 reference first: N = R+1, select 00 (R=10)
      do_load(RMID + 1, 0, 1'b1, 1'b0);
      chk("R9 tune_en after load", int'(tune_en), 1);
      step(RMID);
      chk("R3 up before ref edge", int'(pump_up), 0);
      step(1);
      chk("R3 up pulse", int'(pump_up), 1);
      chk("R3 no dn", int'(pump_dn), 0);
      step(1);
      chk("R3 up ends", int'(pump_up), 0);

      // R3 feedback first: N = R-1
      do_load(RMID - 1, 0, 1'b1, 1'b0);
      step(RMID);
      chk("R3 dn pulse", int'(pump_dn), 1);
      chk("R3 no up", int'(pump_up), 0);
      step(1);
      chk("R3 dn ends", int'(pump_dn), 0);

      // R4 coincident edges, then R5 exact lock cycle
      do_load(RMID, 0, 1'b1, 1'b0);
      step(RMID + 1);
      chk("R4 no up on coincidence", int'(pump_up), 0);
      chk("R4 no dn on coincidence", int'(pump_dn), 0);
      step(3 * RMID - 1);
      chk("R5 not yet locked at edge 4R", int'(lock_n), 1);
      step(1);
      chk("R5 locked after edge 4R+1", int'(lock_n), 0);
      chk("R7 no auto keeps cp_hi", int'(cp_hi), 1);
      chk("R7 no auto acp", int'(acp), 1);

      // R9 reload while locked
      do_load(RMID, 0, 1'b0, 1'b0);
      chk("R9 load clears lock", int'(lock_n), 1);
      chk("R7 low current select", int'(cp_hi), 0);

      // R7 auto reduction
      do_load(RMID, 0, 1'b1, 1'b1);
      chk("R7 cp_hi before lock", int'(cp_hi), 1);
      chk("R7 acp before lock", int'(acp), 1);
      step(4 * RMID + 2);
      chk("R5 locked", int'(lock_n), 0);
      chk("R7 cp_hi forced low", int'(cp_hi), 0);
      chk("R7 acp low", int'(acp), 0);

      // R6 withhold feedback strobe
      @(negedge clk);
      rf_en = 1'b0;
      step(1);
      chk("R6 lock held inside period", int'(lock_n), 0);
      step(2 * RMID + 2);
      chk("R6 lock lost", int'(lock_n), 1);
      chk("R6 R7 cp_hi restored", int'(cp_hi), 1);
      chk("R6 R7 acp restored", int'(acp), 1);
      @(negedge clk);
      rf_en = 1'b1;

      // R1 R2 sweep: lock exactly when N equals the selected ratio
      for (int sel = 0; sel < 4; sel++) begin
         for (int n = 0; n < (1 << NW); n++) begin
            int r;
            r = ratio_of(sel);
            do_load(n, sel, 1'b1, 1'b0);
            step(6 * r + 4);
            chk($sformatf("R1 R2 sel=%0d N=%0d lock_n", sel, n),
                int'(lock_n), (n == r) ? 0 : 1);
         end
      end

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule